// File: doc/BRIEF.md
# Windowed Edge-Frequency Meter

This block measures the frequency of a digital track-A input. The input first passes through a two-flop synchroniser and a rising-edge detector. A rising edge opens a measurement. The block then counts further rising edges, and it counts elapsed time in 100 ns ticks taken from a local prescaler. When the programmed window has run out, the measurement does not stop at once. It stays open until the next rising edge. That edge closes it, so both ends of the interval fall on real input edges and the window length adds no quantisation error.

At the closing edge, a multi-cycle restoring divider forms the result in hertz as edges × 10,000,000 / ticks. A one-cycle done pulse marks every update of the result. If no closing edge arrives within the wait limit, the reported frequency is forced to zero and the valid flag drops. A gate-blocked indication or a restart strobe cancels any measurement in flight and leaves the last result as it was.

Top module: `freq_meter`

## Requirements
- R1: After synchronous reset, freq_hz is 0, freq_valid is 0 and freq_done is 0.
- R2: A measurement opens on the first synchronised rising edge of track_a seen while idle. When it completes, freq_hz = floor(E × 10,000,000 / T) and freq_valid = 1. E is the number of rising edges after the opening edge, counting the closing edge. T is the number of 100 ns ticks between the opening and closing edges.
- R3: The window lasts win_us × TICKS_PER_US ticks. A win_us of 0 is treated as 1.
- R4: After the window has expired, the first rising edge closes the measurement. Edges that arrive while the window is still running are counted but do not close it.
- R5: If the closing edge has not arrived after the wait limit, the block sets freq_hz to 0 and freq_valid to 0 and pulses freq_done. The wait limit is wait_ms milliseconds, with 0 treated as 1 and any value above 1600 clamped to 1600. Whenever freq_valid is 0, freq_hz is 0.
- R6: While gate_block is 1, no measurement opens and any open measurement is discarded. freq_hz, freq_valid and freq_done are left untouched.
- R7: A restart pulse discards any open measurement or division in progress, and the previous outputs stay as they were.
- R8: freq_hz and freq_valid change only in a cycle where freq_done is 1.
- R9: freq_done is high for exactly one cycle per update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| track_a | input | 1 | Asynchronous track-A input |
| gate_block | input | 1 | Counter gate is blocking |
| restart | input | 1 | Restart / reset strobe |
| win_us | input | WIN_W | Window length in microseconds |
| wait_ms | input | WAIT_W | Wait limit for the closing edge in milliseconds |
| freq_hz | output | FREQ_W | Last measured frequency in Hz |
| freq_valid | output | 1 | Result is a valid measurement |
| freq_done | output | 1 | One-cycle pulse on each result update |

## Verification
The assertions assume that win_us and wait_ms are changed only while no measurement is open. They also assume that any restart or gate_block activity is meant to discard the result in flight. The stimulus respects this: it changes the settings only after track_a has been quiet long enough for the previous result to appear. Edge periods are whole multiples of the tick prescale, and the window is chosen so that no edge lands within one tick of the window expiring. With those choices the bench can compute E and T exactly from the stimulus, without any sensitivity to prescaler phase.

// File: rtl/freqm_pkg.sv
package freqm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WINDOW,
        ST_WAIT,
        ST_DIV
    } meas_state_t;

    localparam int unsigned WAIT_MAX_MS = 1600;

    function automatic int unsigned clamp_lo1(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned clamp_wait(input int unsigned v);
        int unsigned r;
        r = clamp_lo1(v);
        return (r > WAIT_MAX_MS) ? WAIT_MAX_MS : r;
    endfunction

endpackage

// File: rtl/freqm_edge_sync.sv
module freqm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/freqm_tick_gen.sv
module freqm_tick_gen #(
    parameter int CLK_PER_TICK = 10
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || pre_q == LAST) pre_q <= '0;
        else                      pre_q <= pre_q + 1'b1;
    end

    assign tick = (pre_q == LAST);
endmodule

// File: rtl/freqm_divider.sv
module freqm_divider #(
    parameter int NUM_W = 56,
    parameter int DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             done
);
    localparam int CW = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] sh_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CW-1:0]    left_q;
    logic             busy_q;

    logic [DEN_W:0]   trial;
    logic             fits;
    logic [DEN_W:0]   diff;

    always_comb begin
        trial = {rem_q, sh_q[NUM_W-1]};
        fits  = trial >= {1'b0, den_q};
        diff  = trial - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            left_q <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy_q <= 1'b0;
            end else if (start) begin
                sh_q   <= num;
                rem_q  <= '0;
                den_q  <= den;
                left_q <= CW'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q  <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                sh_q   <= {sh_q[NUM_W-2:0], fits};
                left_q <= left_q - 1'b1;
                if (left_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign quo = sh_q;
endmodule

// File: rtl/freq_meter.sv
module freq_meter
    import freqm_pkg::*;
#(
    parameter int CLK_PER_TICK = 10,
    parameter int TICKS_PER_US = 10,
    parameter int US_PER_MS    = 1000,
    parameter int TICK_HZ      = 10_000_000,
    parameter int WIN_W        = 16,
    parameter int WAIT_W       = 11,
    parameter int CNT_W        = 32,
    parameter int FREQ_W       = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              track_a,
    input  logic              gate_block,
    input  logic              restart,
    input  logic [WIN_W-1:0]  win_us,
    input  logic [WAIT_W-1:0] wait_ms,
    output logic [FREQ_W-1:0] freq_hz,
    output logic              freq_valid,
    output logic              freq_done
);
    localparam int NUM_W = CNT_W + 24;

    meas_state_t      st_q;
    logic [CNT_W-1:0] span_q, edges_q, wait_q;
    logic [CNT_W-1:0] win_ticks, wait_ticks;
    logic [NUM_W-1:0] num_q, quo;
    logic [CNT_W-1:0] den_q;
    logic             go_q, div_done, rise, tick, abort;

    freqm_edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(track_a), .rise(rise)
    );

    freqm_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    freqm_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
        .clk(clk), .rst(rst), .start(go_q), .abort(abort),
        .num(num_q), .den(den_q), .quo(quo), .done(div_done)
    );

    always_comb begin
        abort      = restart | gate_block;
        win_ticks  = CNT_W'(clamp_lo1(32'(win_us))) * CNT_W'(TICKS_PER_US);
        wait_ticks = CNT_W'(clamp_wait(32'(wait_ms))) * CNT_W'(US_PER_MS)
                     * CNT_W'(TICKS_PER_US);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            span_q     <= '0;
            edges_q    <= '0;
            wait_q     <= '0;
            num_q      <= '0;
            den_q      <= '0;
            go_q       <= 1'b0;
            freq_hz    <= '0;
            freq_valid <= 1'b0;
            freq_done  <= 1'b0;
        end else begin
            go_q      <= 1'b0;
            freq_done <= 1'b0;
            if (abort) begin
                st_q <= ST_IDLE;
            end else begin
                case (st_q)
                    ST_IDLE: if (rise) begin
                        span_q  <= '0;
                        edges_q <= '0;
                        st_q    <= ST_WINDOW;
                    end
                    ST_WINDOW: begin
                        if (tick) span_q <= span_q + 1'b1;
                        if (rise) edges_q <= edges_q + 1'b1;
                        if (span_q >= win_ticks) begin
                            wait_q <= '0;
                            st_q   <= ST_WAIT;
                        end
                    end
                    ST_WAIT: begin
                        if (tick) begin
                            span_q <= span_q + 1'b1;
                            wait_q <= wait_q + 1'b1;
                        end
                        if (rise) begin
                            num_q <= NUM_W'(edges_q + 1'b1) * NUM_W'(TICK_HZ);
                            den_q <= tick ? span_q + 1'b1 : span_q;
                            go_q  <= 1'b1;
                            st_q  <= ST_DIV;
                        end else if (wait_q >= wait_ticks) begin
                            freq_hz    <= '0;
                            freq_valid <= 1'b0;
                            freq_done  <= 1'b1;
                            st_q       <= ST_IDLE;
                        end
                    end
                    ST_DIV: if (div_done) begin
                        freq_hz    <= FREQ_W'(quo);
                        freq_valid <= 1'b1;
                        freq_done  <= 1'b1;
                        st_q       <= ST_IDLE;
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/freq_meter_chk.sv
module freq_meter_chk #(
    parameter int FREQ_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              gate_block,
    input logic              restart,
    input logic [FREQ_W-1:0] freq_hz,
    input logic              freq_valid,
    input logic              freq_done
);
    // R5: an invalid result always reads as zero
    a_r5_invalid_zero: assert property (@(posedge clk) disable iff (rst)
        !freq_valid |-> freq_hz == '0);

    // R8: outputs move only together with the done pulse
    a_r8_hold_freq: assert property (@(posedge clk) disable iff (rst)
        !freq_done |=> (freq_done || $stable(freq_hz)));
    a_r8_hold_valid: assert property (@(posedge clk) disable iff (rst)
        !freq_done |=> (freq_done || $stable(freq_valid)));

    // R9: done lasts a single cycle
    a_r9_single_done: assert property (@(posedge clk) disable iff (rst)
        freq_done |=> !freq_done);

    // R6: no update right after a blocked cycle
    a_r6_gate_blocks: assert property (@(posedge clk) disable iff (rst)
        gate_block |=> !freq_done);

    // R7: no update right after a restart strobe
    a_r7_restart_drops: assert property (@(posedge clk) disable iff (rst)
        restart |=> !freq_done);
endmodule

bind freq_meter freq_meter_chk #(.FREQ_W(FREQ_W)) u_chk (
    .clk(clk), .rst(rst), .gate_block(gate_block), .restart(restart),
    .freq_hz(freq_hz), .freq_valid(freq_valid), .freq_done(freq_done)
);

// File: tb/tb_freq_meter.sv
module tb_freq_meter;
    localparam int CPT = 2;
    localparam int TPU = 2;
    localparam int UPM = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        track_a = 1'b0;
    logic        gate_block = 1'b0;
    logic        restart = 1'b0;
    logic [15:0] win_us = 16'd5;
    logic [10:0] wait_ms = 11'd1600;
    logic [31:0] freq_hz;
    logic        freq_valid;
    logic        freq_done;

    int checks = 0;
    int fails  = 0;
    int dones  = 0;
    logic [32:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    freq_meter #(.CLK_PER_TICK(CPT), .TICKS_PER_US(TPU), .US_PER_MS(UPM)) dut (
        .clk(clk), .rst(rst), .track_a(track_a), .gate_block(gate_block),
        .restart(restart), .win_us(win_us), .wait_ms(wait_ms),
        .freq_hz(freq_hz), .freq_valid(freq_valid), .freq_done(freq_done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each done pulse
    always @(negedge clk) begin
        if (!rst && freq_done) begin
            dones++;
            if (exp_q.size() == 0) begin
                check("R8 unexpected update", 64'({freq_valid, freq_hz}), 64'h1_FFFF_FFFF);
            end else begin
                logic [32:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 64'(freq_hz), 64'(e[31:0]));
                check(t, 64'(freq_valid), 64'(e[32]));
            end
        end
    end

    task automatic pulses(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            track_a = 1'b1;
            repeat (half) @(negedge clk);
            track_a = 1'b0;
            repeat (half) @(negedge clk);
        end
    endtask

    // smallest edge count whose tick span exceeds the window by a tick margin
    function automatic int edges_needed(input int wticks, input int tpe);
        int k = 1;
        while (k * tpe < wticks + 2) k++;
        return k;
    endfunction

    task automatic measure(input string tag, input int win, input int half);
        int w, tpe, k;
        logic [63:0] f;
        win_us = 16'(win);
        w   = ((win == 0) ? 1 : win) * TPU;
        tpe = (2 * half) / CPT;
        k   = edges_needed(w, tpe);
        f   = (64'(k) * 64'd10_000_000) / 64'(k * tpe);
        exp_q.push_back({1'b1, f[31:0]});
        tag_q.push_back(tag);
        pulses(k + 1, half);
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        check({tag, " result arrived"}, 64'(exp_q.size()), 64'd0);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int d0;
        logic [31:0] f0;
        repeat (4) @(negedge clk);
        check("R1 freq", 64'(freq_hz), 0);
        check("R1 valid", 64'(freq_valid), 0);
        check("R1 done", 64'(freq_done), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        measure("R2 R4 win5 p6", 5, 3);      // 4 edges / 12 ticks
        measure("R4 win9 p8", 9, 4);         // 5 edges / 20 ticks
        measure("R3 win1 p22", 1, 11);       // 1 edge / 11 ticks
        measure("R3 win0 treated as 1", 0, 11);
        measure("R3 R2 win20 p12", 20, 6);   // 7 edges / 42 ticks

        // R6: edges while gated start nothing
        d0 = dones; f0 = freq_hz;
        gate_block = 1'b1;
        pulses(12, 3);
        repeat (20) @(negedge clk);
        gate_block = 1'b0;
        repeat (60) @(negedge clk);
        check("R6 no update while gated", 64'(dones - d0), 0);
        check("R6 freq kept", 64'(freq_hz), 64'(f0));

        // R6: gate mid-measurement discards it (timeout would fire otherwise)
        wait_ms = 11'd1; win_us = 16'd20;
        d0 = dones;
        pulses(3, 3);
        gate_block = 1'b1;
        repeat (3) @(negedge clk);
        gate_block = 1'b0;
        repeat (300) @(negedge clk);
        check("R6 open measurement dropped", 64'(dones - d0), 0);
        check("R6 valid kept", 64'(freq_valid), 1);

        // R7: restart discards the open measurement
        d0 = dones;
        pulses(3, 3);
        repeat (5) @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        repeat (300) @(negedge clk);
        check("R7 no update after restart", 64'(dones - d0), 0);
        check("R7 freq kept", 64'(freq_hz), 64'(f0));

        // R5: no closing edge within the wait limit
        exp_q.push_back(33'd0);
        tag_q.push_back("R5 timeout");
        pulses(1, 3);
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        check("R5 timeout update", 64'(exp_q.size()), 0);

        // R2: fresh measurement after timeout
        wait_ms = 11'd1600;
        measure("R2 after timeout", 5, 3);

        repeat (20) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule